// File: doc/BRIEF.md
# Chained-Key Frame Classification Sequencer

This block steps through a received frame one byte at a time and drives an external ternary lookup table with a 15-bit search key. Each key joins the 7-bit address that the previous lookup returned (high bits) with an 8-bit operand (low bits). The operand is either the newly accepted frame byte or the value of an 8-bit scratch register. Every lookup returns an address and a 16-bit rule word. The sequencer applies that rule word in the cycle it arrives. The rule word can load the scratch register, load or decrement a 5-bit loop counter, pick the operand for the next key, and fire one-cycle action pulses. The actions are pause-counter byte loads, pause-timer start, frame discard, host wake and host interrupt.

A frame opens with a byte flagged as start-of-frame. At that point the chained address, the scratch register and the loop counter all restart at zero. Because the table never returns address zero, a rule keyed on a previous address of zero can only hit the opening byte. A rule can run a loop over the bytes that follow. When a decrement expires the counter, the next key carries the rule's own address minus one. This lets a different rule match and so leaves the loop. The table, the pause timer and the statistics logic sit outside this block.

Top module: `pkt_cls_seq`

## Requirements
- R1: Each lookup raises `keyValid` for exactly one cycle. `keyWord[14:8]` is the chained address and `keyWord[7:0]` is the operand. When the rule word selects byte operands, the chained address is the previously returned address.
- R2: A start-of-frame byte accepted while idle begins a frame. It clears the chained address, the scratch register and the loop counter. The frame's first key is {0, that byte}.
- R3: Rule bit 0 picks the next operand: 0 takes the next accepted byte, 1 takes the scratch register. With bit 0 = 1 and bit 15 = 1, one byte is accepted and discarded before the register-operand lookup. With bit 0 = 1 and bit 15 = 0, the lookup is issued without accepting a byte.
- R4: Rule bits 3:1 = 1 load the scratch register from the current byte. Bits 3:1 = 2 load it from the returned address, zero-extended.
- R5: Rule bits 3:1 = 3 load the counter from bits 8:4. Bits 3:1 = 4 decrement it. A decrement from 1 or from 0 expires the counter, leaves it at 0, and makes the next chained address the returned address minus one.
- R6: In the cycle a rule word is applied, rule bits 9..14 drive one-cycle pulses on pauseHiLoad, pauseLoLoad, pauseStart, dropPulse, wakePulse and intrPulse in that order. `pauseByte` equals the current byte.
- R7: `dropFlag` rises the cycle after a rule with bit 12 set is applied and stays high until the frame ends.
- R8: After the rule word for the lookup of the end-of-frame byte is applied, no further lookup is issued and the block returns to idle.
- R9: While idle, bytes without start-of-frame are accepted and discarded. A response arriving while no lookup is outstanding causes no pulse and no state change. A start-of-frame flag inside a frame is treated as an ordinary byte.
- R10: After reset the block is idle: `inReady` is 1, and `keyValid`, all pulses and `dropFlag` are 0.
- R11: `inReady` is high only while idle or waiting for a byte. A lookup is issued the cycle after a byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Frame byte valid |
| inData | input | 8 | Frame byte |
| inSof | input | 1 | Byte opens a frame |
| inEof | input | 1 | Byte closes a frame |
| inReady | output | 1 | Byte accepted when high with inValid |
| keyValid | output | 1 | Lookup strobe |
| keyWord | output | 15 | Search key {chained address, operand} |
| respValid | input | 1 | Lookup result valid |
| respAddr | input | 7 | Matching table address |
| respCtrl | input | 16 | Rule word of the matching entry |
| pauseHiLoad | output | 1 | Load pause counter high byte |
| pauseLoLoad | output | 1 | Load pause counter low byte |
| pauseStart | output | 1 | Start pause timer |
| dropPulse | output | 1 | Discard frame pulse |
| wakePulse | output | 1 | Wake host pulse |
| intrPulse | output | 1 | Interrupt host pulse |
| pauseByte | output | 8 | Byte for the pause counter loads |
| dropFlag | output | 1 | Frame marked for discard |

## Verification
A corrupted chained address, scratch register or loop counter does not show at once. It shows in the next `keyWord`, one to four cycles after the rule that caused it. A counter error may only appear several lookups later, when an expiry shifts the address by one. So the bench compares every key against an independent model rather than only frame results. A wrong state in the sequencing control shows within one cycle as a misplaced `inReady` or `keyValid`, or as a pulse outside a response cycle.

// File: rtl/pkt_cls_pkg.sv
package pkt_cls_pkg;
  localparam int ADDR_W  = 7;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 5;
  localparam int NUM_ACT = 6;
  localparam int OP_W    = 3;

  localparam int ACT_PHI   = 0;
  localparam int ACT_PLO   = 1;
  localparam int ACT_START = 2;
  localparam int ACT_DROP  = 3;
  localparam int ACT_WAKE  = 4;
  localparam int ACT_INTR  = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NONE  = 3'd0,
    OP_XBYTE = 3'd1,
    OP_XADDR = 3'd2,
    OP_TOC   = 3'd3,
    OP_DEC   = 3'd4
  } ruleOp_e;

  typedef struct packed {
    logic frameStart;
    logic byteTake;
    logic apply;
    logic selX;
  } dpStb_t;
endpackage

// File: rtl/pkt_cls_dp.sv
module pkt_cls_dp
  import pkt_cls_pkg::*;
#(
  parameter int ADDR_W = pkt_cls_pkg::ADDR_W,
  parameter int BYTE_W = pkt_cls_pkg::BYTE_W,
  parameter int CNT_W  = pkt_cls_pkg::CNT_W,
  localparam int KEY_W = ADDR_W + BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStb_t            stb,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inEof,
  input  logic [ADDR_W-1:0] respAddr,
  input  logic [OP_W-1:0]   ruleOp,
  input  logic [CNT_W-1:0]  tocVal,
  output logic [KEY_W-1:0]  keyWord,
  output logic [BYTE_W-1:0] curByte,
  output logic              curEof
);
  logic [ADDR_W-1:0] prevAddr;
  logic [BYTE_W-1:0] xReg;
  logic [CNT_W-1:0]  loopCnt;
  logic              expired;
  ruleOp_e           op;

  assign op      = ruleOp_e'(ruleOp);
  assign expired = (op == OP_DEC) && (loopCnt <= CNT_W'(1));
  assign keyWord = {prevAddr, (stb.selX ? xReg : curByte)};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevAddr <= '0;
      xReg     <= '0;
      loopCnt  <= '0;
      curByte  <= '0;
      curEof   <= 1'b0;
    end else if (stb.frameStart) begin
      prevAddr <= '0;
      xReg     <= '0;
      loopCnt  <= '0;
      curByte  <= inData;
      curEof   <= inEof;
    end else if (stb.byteTake) begin
      curByte  <= inData;
      curEof   <= inEof;
    end else if (stb.apply) begin
      prevAddr <= expired ? (respAddr - ADDR_W'(1)) : respAddr;
      case (op)
        OP_XBYTE: xReg    <= curByte;
        OP_XADDR: xReg    <= BYTE_W'(respAddr);
        OP_TOC:   loopCnt <= tocVal;
        OP_DEC:   loopCnt <= expired ? '0 : (loopCnt - CNT_W'(1));
        default:  ;
      endcase
    end
  end

  // R2: a frame start leaves chained address and scratch register cleared
  assert_frame_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.frameStart) |-> (prevAddr == '0 && xReg == '0));

  // R5: a non-expiring decrement lowers the counter by exactly one
  assert_dec_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.apply && op == OP_DEC && loopCnt > CNT_W'(1)) |=>
      (loopCnt == $past(loopCnt) - CNT_W'(1)));
endmodule

// File: rtl/pkt_cls_ctrl.sv
module pkt_cls_ctrl
  import pkt_cls_pkg::*;
#(
  parameter int NACT = pkt_cls_pkg::NUM_ACT
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            inSof,
  input  logic            respValid,
  input  logic            ruleSelX,
  input  logic            ruleConsume,
  input  logic [NACT-1:0] ruleAct,
  input  logic            curEof,
  output logic            inReady,
  output logic            keyValid,
  output dpStb_t          stb,
  output logic [NACT-1:0] actions,
  output logic            dropFlag
);
  typedef enum logic [1:0] {S_IDLE, S_WBYTE, S_ISSUE, S_WRESP} seqState_e;

  seqState_e state, stateNext;
  logic      useX, useXNext;

  always_comb begin
    stateNext      = state;
    useXNext       = useX;
    inReady        = 1'b0;
    keyValid       = 1'b0;
    stb.frameStart = 1'b0;
    stb.byteTake   = 1'b0;
    stb.apply      = 1'b0;
    stb.selX       = useX;
    case (state)
      S_IDLE: begin
        inReady = 1'b1;
        if (inValid && inSof) begin
          stb.frameStart = 1'b1;
          useXNext       = 1'b0;
          stateNext      = S_ISSUE;
        end
      end
      S_WBYTE: begin
        inReady = 1'b1;
        if (inValid) begin
          stb.byteTake = 1'b1;
          stateNext    = S_ISSUE;
        end
      end
      S_ISSUE: begin
        keyValid  = 1'b1;
        stateNext = S_WRESP;
      end
      S_WRESP: begin
        if (respValid) begin
          stb.apply = 1'b1;
          if (curEof) begin
            stateNext = S_IDLE;
          end else if (!ruleSelX) begin
            useXNext  = 1'b0;
            stateNext = S_WBYTE;
          end else if (ruleConsume) begin
            useXNext  = 1'b1;
            stateNext = S_WBYTE;
          end else begin
            useXNext  = 1'b1;
            stateNext = S_ISSUE;
          end
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign actions = stb.apply ? ruleAct : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      useX     <= 1'b0;
      dropFlag <= 1'b0;
    end else begin
      state <= stateNext;
      useX  <= useXNext;
      if (stb.apply) begin
        if (curEof)                  dropFlag <= 1'b0;
        else if (ruleAct[ACT_DROP])  dropFlag <= 1'b1;
      end
    end
  end

  // R1: the lookup strobe never lasts more than one cycle
  assert_key_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    keyValid |=> !keyValid);

  // R6: action pulses only appear alongside a returned result
  assert_act_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|actions) |-> respValid);

  // R7: the discard mark is never held while idle
  assert_drop_inframe_R7: assert property (@(posedge clk) disable iff (!rstN)
    dropFlag |-> (state != S_IDLE));
endmodule

// File: rtl/pkt_cls_seq.sv
module pkt_cls_seq
  import pkt_cls_pkg::*;
#(
  parameter int ADDR_W = pkt_cls_pkg::ADDR_W,
  parameter int BYTE_W = pkt_cls_pkg::BYTE_W,
  parameter int CNT_W  = pkt_cls_pkg::CNT_W,
  localparam int KEY_W    = ADDR_W + BYTE_W,
  localparam int OP_LSB   = 1,
  localparam int TOC_LSB  = OP_LSB + OP_W,
  localparam int ACT_LSB  = TOC_LSB + CNT_W,
  localparam int CONS_BIT = ACT_LSB + NUM_ACT,
  localparam int CTRL_W   = CONS_BIT + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inSof,
  input  logic              inEof,
  output logic              inReady,
  output logic              keyValid,
  output logic [KEY_W-1:0]  keyWord,
  input  logic              respValid,
  input  logic [ADDR_W-1:0] respAddr,
  input  logic [CTRL_W-1:0] respCtrl,
  output logic              pauseHiLoad,
  output logic              pauseLoLoad,
  output logic              pauseStart,
  output logic              dropPulse,
  output logic              wakePulse,
  output logic              intrPulse,
  output logic [BYTE_W-1:0] pauseByte,
  output logic              dropFlag
);
  dpStb_t             stb;
  logic [NUM_ACT-1:0] actions;
  logic               curEof;

  pkt_cls_ctrl #(.NACT(NUM_ACT)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inSof      (inSof),
    .respValid  (respValid),
    .ruleSelX   (respCtrl[0]),
    .ruleConsume(respCtrl[CONS_BIT]),
    .ruleAct    (respCtrl[ACT_LSB +: NUM_ACT]),
    .curEof     (curEof),
    .inReady    (inReady),
    .keyValid   (keyValid),
    .stb        (stb),
    .actions    (actions),
    .dropFlag   (dropFlag)
  );

  pkt_cls_dp #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .inData  (inData),
    .inEof   (inEof),
    .respAddr(respAddr),
    .ruleOp  (respCtrl[OP_LSB +: OP_W]),
    .tocVal  (respCtrl[TOC_LSB +: CNT_W]),
    .keyWord (keyWord),
    .curByte (pauseByte),
    .curEof  (curEof)
  );

  assign pauseHiLoad = actions[ACT_PHI];
  assign pauseLoLoad = actions[ACT_PLO];
  assign pauseStart  = actions[ACT_START];
  assign dropPulse   = actions[ACT_DROP];
  assign wakePulse   = actions[ACT_WAKE];
  assign intrPulse   = actions[ACT_INTR];

  // R11: no byte is taken while a lookup is being issued
  assert_ready_key_R11: assert property (@(posedge clk) disable iff (!rstN)
    keyValid |-> !inReady);
endmodule

// File: tb/pkt_cls_seq_tb.sv
module pkt_cls_seq_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [7:0] inData = '0;
  logic respValid = 1'b0;
  logic [6:0] respAddr = '0;
  logic [15:0] respCtrl = '0;
  logic inReady, keyValid, dropFlag;
  logic [14:0] keyWord;
  logic [7:0] pauseByte;
  logic pauseHiLoad, pauseLoLoad, pauseStart, dropPulse, wakePulse, intrPulse;
  logic [5:0] actVec;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";
  logic [22:0] respQ[$];

  bit mInFrame = 0, mAwait = 0, mIssue = 0, mWait = 0, mUseX = 0, mDrop = 0, mCurEof = 0;
  logic [6:0] mPrev = '0;
  logic [7:0] mX = '0, mCur = '0;
  int mC = 0;

  always #5 clk = ~clk;

  pkt_cls_seq u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inSof(inSof), .inEof(inEof),
    .inReady(inReady), .keyValid(keyValid), .keyWord(keyWord), .respValid(respValid),
    .respAddr(respAddr), .respCtrl(respCtrl), .pauseHiLoad(pauseHiLoad), .pauseLoLoad(pauseLoLoad),
    .pauseStart(pauseStart), .dropPulse(dropPulse), .wakePulse(wakePulse), .intrPulse(intrPulse),
    .pauseByte(pauseByte), .dropFlag(dropFlag));

  assign actVec = {intrPulse, wakePulse, dropPulse, pauseStart, pauseLoLoad, pauseHiLoad};

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input bit sel, input logic [2:0] op, input logic [4:0] toc,
                                     input logic [5:0] fl, input bit cons);
    return {cons, fl, toc, op, sel};
  endfunction

  task automatic pr(input logic [6:0] a, input logic [15:0] c);
    respQ.push_back({a, c});
  endtask

  // Reference model and comparison, once per cycle between active edges
  always @(negedge clk) begin
    logic [5:0] expAct;
    logic [14:0] expKey;
    bit app, expd;
    if (rstN && !done) begin
      chk(inReady == (!mInFrame || mAwait), "R11", "inReady", inReady, !mInFrame || mAwait);
      chk(keyValid == mIssue, "R1", "keyValid", keyValid, mIssue);
      if (mIssue && keyValid) begin
        expKey = {mPrev, (mUseX ? mX : mCur)};
        chk(keyWord == expKey, tag, "keyWord", keyWord, expKey);
      end
      app = mWait && respValid;
      expAct = app ? respCtrl[14:9] : 6'd0;
      chk(actVec == expAct, app ? "R6" : "R9", "actions", actVec, expAct);
      if (app && (respCtrl[9] || respCtrl[10]))
        chk(pauseByte == mCur, "R6", "pauseByte", pauseByte, mCur);
      chk(dropFlag == mDrop, "R7", "dropFlag", dropFlag, mDrop);

      if (mIssue) begin
        mIssue = 0; mWait = 1;
      end else if (app) begin
        expd = 0;
        case (respCtrl[3:1])
          3'd1: mX = mCur;
          3'd2: mX = {1'b0, respAddr};
          3'd3: mC = int'(respCtrl[8:4]);
          3'd4: if (mC <= 1) begin expd = 1; mC = 0; end else mC = mC - 1;
          default: ;
        endcase
        mPrev = expd ? respAddr - 7'd1 : respAddr;
        if (respCtrl[12]) mDrop = 1;
        mWait = 0;
        if (mCurEof) begin mInFrame = 0; mDrop = 0; end
        else if (!respCtrl[0]) begin mAwait = 1; mUseX = 0; end
        else if (respCtrl[15]) begin mAwait = 1; mUseX = 1; end
        else begin mIssue = 1; mUseX = 1; end
      end else if (inValid && (!mInFrame || mAwait)) begin
        if (!mInFrame) begin
          if (inSof) begin
            mInFrame = 1; mPrev = '0; mX = '0; mC = 0; mDrop = 0;
            mCur = inData; mCurEof = inEof; mIssue = 1; mUseX = 0;
          end
        end else begin
          mCur = inData; mCurEof = inEof; mAwait = 0; mIssue = 1;
        end
      end
    end
  end

  // Lookup table stand-in: scripted results first, random ones after
  initial begin
    logic [22:0] ent;
    logic [15:0] rc;
    forever begin
      @(negedge clk);
      if (keyValid && rstN) begin
        if (respQ.size() > 0) ent = respQ.pop_front();
        else begin
          rc = 16'($urandom);
          if (rc[0]) rc[15] = 1'b1;
          ent = {7'(2 + $urandom % 126), rc};
        end
        repeat ($urandom % 3) @(posedge clk);
        @(posedge clk); #1;
        respValid = 1'b1; respAddr = ent[22:16]; respCtrl = ent[15:0];
        @(posedge clk); #1;
        respValid = 1'b0;
      end
    end
  end

  task automatic sendByte(input logic [7:0] d, input bit sof, input bit eof);
    inValid = 1'b1; inData = d; inSof = sof; inEof = eof;
    forever begin
      @(negedge clk);
      if (inReady) break;
    end
    @(posedge clk); #1;
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
  endtask

  task automatic waitIdle();
    while (mInFrame) @(posedge clk);
    @(negedge clk);
    chk(inReady == 1'b1 && keyValid == 1'b0, "R8", "idle after end of frame", {inReady, keyValid}, 2'b10);
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(inReady == 1 && keyValid == 0 && actVec == 0 && dropFlag == 0, "R10", "reset state",
        {inReady, keyValid, actVec, dropFlag}, 9'b100000000);
    @(posedge clk); #1 rstN = 1'b1;
    repeat (2) @(posedge clk); #1;

    // R1: plain byte chaining
    tag = "R1";
    pr(7'd5, cw(0, 3'd0, 5'd0, 6'd0, 0));
    pr(7'd9, cw(0, 3'd0, 5'd0, 6'd0, 0));
    pr(7'd1, cw(0, 3'd0, 5'd0, 6'd0, 0));
    sendByte(8'hA1, 1, 0); sendByte(8'hB2, 0, 0); sendByte(8'hC3, 0, 1);
    waitIdle();

    // R3 and R4: register operand, consume flag, register loads
    tag = "R3";
    pr(7'd20, cw(1, 3'd1, 5'd0, 6'd0, 0));
    pr(7'd21, cw(0, 3'd2, 5'd0, 6'd0, 0));
    pr(7'd30, cw(1, 3'd0, 5'd0, 6'd0, 1));
    pr(7'd31, cw(0, 3'd0, 5'd0, 6'd0, 0));
    pr(7'd33, cw(1, 3'd0, 5'd0, 6'd0, 0));
    sendByte(8'h10, 1, 0); sendByte(8'h22, 0, 0); sendByte(8'hEE, 0, 0); sendByte(8'h44, 0, 1);
    waitIdle();

    // R5: counted loop with expiry from one
    tag = "R5";
    pr(7'd40, cw(0, 3'd3, 5'd2, 6'd0, 0));
    pr(7'd41, cw(0, 3'd4, 5'd0, 6'd0, 0));
    pr(7'd41, cw(0, 3'd4, 5'd0, 6'd0, 0));
    pr(7'd3,  cw(0, 3'd0, 5'd0, 6'd0, 0));
    sendByte(8'h01, 1, 0); sendByte(8'h02, 0, 0); sendByte(8'h03, 0, 0); sendByte(8'h04, 0, 1);
    waitIdle();
    // R5: decrement at zero also expires
    pr(7'd50, cw(0, 3'd4, 5'd0, 6'd0, 0));
    pr(7'd2,  cw(0, 3'd0, 5'd0, 6'd0, 0));
    sendByte(8'h55, 1, 0); sendByte(8'h66, 0, 1);
    waitIdle();

    // R6 and R7: action pulses, pause byte, discard mark
    tag = "R6";
    pr(7'd60, cw(0, 3'd0, 5'd0, 6'b000001, 0));
    pr(7'd61, cw(0, 3'd0, 5'd0, 6'b001110, 0));
    pr(7'd62, cw(0, 3'd0, 5'd0, 6'b000000, 0));
    pr(7'd63, cw(0, 3'd0, 5'd0, 6'b110000, 0));
    sendByte(8'h7A, 1, 0); sendByte(8'h7B, 0, 0); sendByte(8'h7C, 0, 0); sendByte(8'h7D, 0, 1);
    waitIdle();
    tag = "R7";
    pr(7'd64, cw(0, 3'd0, 5'd0, 6'b111111, 0));
    sendByte(8'h90, 1, 1);
    waitIdle();

    // R9: idle junk, stray result, start flag inside a frame
    tag = "R9";
    sendByte(8'h33, 0, 0); sendByte(8'h34, 0, 1);
    respValid = 1'b1; respAddr = 7'd99; respCtrl = cw(1, 3'd2, 5'd7, 6'b111111, 0);
    @(posedge clk); #1 respValid = 1'b0;
    @(posedge clk); #1;
    pr(7'd70, cw(0, 3'd0, 5'd0, 6'd0, 0));
    pr(7'd71, cw(0, 3'd0, 5'd0, 6'd0, 0));
    pr(7'd72, cw(0, 3'd0, 5'd0, 6'd0, 0));
    sendByte(8'h35, 1, 0); sendByte(8'h36, 1, 0); sendByte(8'h37, 0, 1);
    waitIdle();

    // R2: a new frame clears the scratch register loaded by the last one
    tag = "R2";
    pr(7'd75, cw(0, 3'd2, 5'd0, 6'd0, 0));
    sendByte(8'h80, 1, 1);
    waitIdle();
    pr(7'd76, cw(1, 3'd0, 5'd0, 6'd0, 0));
    pr(7'd77, cw(0, 3'd0, 5'd0, 6'd0, 0));
    pr(7'd2,  cw(0, 3'd0, 5'd0, 6'd0, 0));
    sendByte(8'h81, 1, 0); sendByte(8'h82, 0, 1);
    waitIdle();

    // R1: random frames with random rule words
    tag = "R1";
    for (int f = 0; f < 40; f++) begin
      int len;
      len = 1 + int'($urandom % 6);
      for (int b = 0; b < len; b++) begin
        sendByte(8'($urandom), b == 0, b == len - 1);
        repeat ($urandom % 2) @(posedge clk);
        #1;
      end
      waitIdle();
    end

    finishRun();
  end
endmodule